// File: doc/BRIEF.md
# Retriggerable Pulse Burst Generator

This block emits a burst of rectangular pulses each time a rising edge on its trigger input arrives while it is idle. Every pulse is a run of high clock cycles followed by a run of low clock cycles. The pulse count and both lengths come from configuration inputs, and one clock cycle counts as one timebase tick. A typical use is to lock a fixed-rate sample clock to a slow periodic reference, such as a once-per-interval timing mark. Each reference edge restarts the burst, so rate error cannot build up over long runs.

In the default mode the final pulse keeps its full low phase. If the reference period equals the burst length exactly, the next edge lands while the burst is still running and is lost. An optional tail mode shortens only the last low phase to a programmed length, with a floor of two cycles. The block then re-arms before the next reference edge. Edges that arrive during a burst do not start a burst; instead they set a sticky flag that software can inspect and clear.

Top module: `pulse_burst_gen`

## Requirements
- R1: A trigger edge is detected at a clock edge where `trig_in` is 1 and was 0 at the previous clock edge. When it is detected while `busy` is 0, a burst starts and `pulse_out` is 1 from the next cycle.
- R2: `busy` is 1 from the first high cycle of a burst through its last low cycle. A trigger edge seen while `busy` is 1 neither restarts nor lengthens the burst.
- R3: A burst contains `cfg_pulses` pulses. Each pulse is `cfg_high` cycles at 1 followed by `cfg_low` cycles at 0.
- R4: With `cfg_tail_en` = 0, the last pulse keeps its full `cfg_low` low phase, and the block accepts no trigger until that phase has ended.
- R5: With `cfg_tail_en` = 1, the last pulse's low phase lasts max(`cfg_tail_len`, 2) cycles, and the block accepts a trigger as soon as that phase has ended.
- R6: Use a trigger period equal to the full burst length: 10 pulses of 5 high and 5 low cycles, with a trigger every 100 cycles. In default mode, 10 triggers start 5 bursts. With the tail enabled at length 2, they start 10 bursts.
- R7: `pulse_out` is 0 while the block is idle and after reset. A trigger held high for several cycles starts only one burst.
- R8: `missed` is set by a trigger edge that arrives while `busy` is 1. It stays set until a cycle with `miss_clr` = 1 or a reset. If a set and a clear fall in the same cycle, the set wins.
- R9: The configuration inputs are captured when a burst starts. Changes made during a burst take effect from the next burst.
- R10: A value of 0 in `cfg_pulses`, `cfg_high` or `cfg_low` behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one timebase tick |
| rst_n | input | 1 | Synchronous reset, active low |
| trig_in | input | 1 | Trigger, already synchronous to `clk` |
| cfg_pulses | input | PCNT_W | Pulses per burst |
| cfg_high | input | TICK_W | High cycles per pulse |
| cfg_low | input | TICK_W | Low cycles per pulse |
| cfg_tail_en | input | 1 | Enable the shortened final low phase |
| cfg_tail_len | input | TICK_W | Length of the shortened final low phase (floor 2) |
| miss_clr | input | 1 | Clears `missed` (write-one-to-clear strobe) |
| pulse_out | output | 1 | Pulse line |
| busy | output | 1 | Burst in progress |
| missed | output | 1 | Sticky flag: a trigger arrived while busy |

## Verification
Two pairs of events can land in the same cycle. The first pair is the last cycle of a burst and a new trigger edge. The second pair is a missed-trigger set and a `miss_clr` strobe. The bench places the trigger exactly one burst length after the previous one, so the edge coincides with the final low cycle. It also raises `miss_clr` in the same cycle as an edge during a burst. A behavioural model fills a queue with the expected output levels when a burst is accepted. The bench compares `pulse_out`, `busy` and `missed` with this model on every clock and counts the bursts actually started in each period scenario.

// File: rtl/pulse_burst_pkg.sv
// Shared definitions for the pulse burst generator.
package pulse_burst_pkg;
    typedef enum logic [1:0] {PH_IDLE, PH_HIGH, PH_LOW} phase_t;
    // Shortest allowed length of a shortened final low phase.
    localparam int unsigned MIN_TAIL = 2;
endpackage

// File: rtl/trig_edge.sv
// Rising-edge detector for the trigger.
// Assumes trig is already synchronous to clk. A level held high yields one rise.
module trig_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic rise
);
    logic trig_q;

    // Remember the trigger level from the previous clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig;
    end

    // High when the trigger is 1 now and was 0 one cycle earlier.
    assign rise = trig & ~trig_q;
endmodule

// File: rtl/burst_seq.sv
// Burst sequencer: counts pulses and the high/low cycles of each pulse.
// Assumes start is a one-cycle request. Config is captured only on an accepted start.
module burst_seq
    import pulse_burst_pkg::*;
#(
    parameter int unsigned PCNT_W = 16,
    parameter int unsigned TICK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PCNT_W-1:0] cfg_pulses,
    input  logic [TICK_W-1:0] cfg_high,
    input  logic [TICK_W-1:0] cfg_low,
    input  logic              cfg_tail_en,
    input  logic [TICK_W-1:0] cfg_tail_len,
    output logic              pulse,
    output logic              busy,
    output logic              accept
);
    localparam logic [PCNT_W-1:0] P_ONE = PCNT_W'(1);
    localparam logic [TICK_W-1:0] T_ONE = TICK_W'(1);
    localparam logic [TICK_W-1:0] T_MIN = TICK_W'(MIN_TAIL);

    phase_t            phase_q;
    logic [PCNT_W-1:0] pc_q;
    logic [TICK_W-1:0] tc_q, hi_q, lo_q, tail_q;
    logic              trunc_q;
    logic [PCNT_W-1:0] n_eff;
    logic [TICK_W-1:0] h_eff, l_eff, tail_eff;

    // Clamp zero lengths and pick the length of the final low phase.
    always_comb begin
        n_eff    = (cfg_pulses == '0) ? P_ONE : cfg_pulses;
        h_eff    = (cfg_high   == '0) ? T_ONE : cfg_high;
        l_eff    = (cfg_low    == '0) ? T_ONE : cfg_low;
        tail_eff = cfg_tail_en ? ((cfg_tail_len < T_MIN) ? T_MIN : cfg_tail_len) : l_eff;
    end

    assign accept = start && (phase_q == PH_IDLE);
    assign pulse  = (phase_q == PH_HIGH);
    assign busy   = (phase_q != PH_IDLE);

    // Phase and counter sequencing for one burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            pc_q    <= '0;
            tc_q    <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
            tail_q  <= '0;
            trunc_q <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (accept) begin
                        phase_q <= PH_HIGH;
                        pc_q    <= n_eff - P_ONE;
                        tc_q    <= h_eff - T_ONE;
                        hi_q    <= h_eff;
                        lo_q    <= l_eff;
                        tail_q  <= tail_eff;
                        trunc_q <= cfg_tail_en;
                    end
                end
                PH_HIGH: begin
                    if (tc_q == '0) begin
                        phase_q <= PH_LOW;
                        tc_q    <= (pc_q == '0) ? (tail_q - T_ONE) : (lo_q - T_ONE);
                    end else begin
                        tc_q <= tc_q - T_ONE;
                    end
                end
                PH_LOW: begin
                    if (tc_q == '0) begin
                        if (pc_q == '0) begin
                            phase_q <= PH_IDLE;
                        end else begin
                            phase_q <= PH_HIGH;
                            pc_q    <= pc_q - P_ONE;
                            tc_q    <= hi_q - T_ONE;
                        end
                    end else begin
                        tc_q <= tc_q - T_ONE;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    AST_START_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (pulse && busy)) else $error("start latency"); // R1

    AST_ENDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !$past(pulse)) else $error("burst ended in high phase"); // R4

    AST_TAIL_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_HIGH && tc_q == '0 && pc_q == '0 && trunc_q) |=> (tc_q != '0))
        else $error("tail shorter than floor"); // R5
endmodule

// File: rtl/pulse_burst_gen.sv
// Top level: retriggerable finite pulse burst generator with a missed-trigger flag.
// Assumes trig_in is synchronous to clk. One clock cycle is one timebase tick.
module pulse_burst_gen #(
    parameter int unsigned PCNT_W = 16,
    parameter int unsigned TICK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_in,
    input  logic [PCNT_W-1:0] cfg_pulses,
    input  logic [TICK_W-1:0] cfg_high,
    input  logic [TICK_W-1:0] cfg_low,
    input  logic              cfg_tail_en,
    input  logic [TICK_W-1:0] cfg_tail_len,
    input  logic              miss_clr,
    output logic              pulse_out,
    output logic              busy,
    output logic              missed
);
    logic rise, accept, miss_q;

    trig_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (trig_in),
        .rise  (rise)
    );

    burst_seq #(.PCNT_W(PCNT_W), .TICK_W(TICK_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (rise),
        .cfg_pulses   (cfg_pulses),
        .cfg_high     (cfg_high),
        .cfg_low      (cfg_low),
        .cfg_tail_en  (cfg_tail_en),
        .cfg_tail_len (cfg_tail_len),
        .pulse        (pulse_out),
        .busy         (busy),
        .accept       (accept)
    );

    // Sticky missed-trigger flag; a new miss wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)             miss_q <= 1'b0;
        else if (rise && busy)  miss_q <= 1'b1;
        else if (miss_clr)      miss_q <= 1'b0;
    end

    assign missed = miss_q;

    AST_MISS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && busy) |=> missed) else $error("miss not flagged"); // R8

    AST_MISS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (missed && !miss_clr) |=> missed) else $error("miss flag dropped"); // R8

    AST_MISS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_clr && !(rise && busy)) |=> !missed) else $error("miss flag not cleared"); // R8

    AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && busy) |-> !accept) else $error("start while busy"); // R2
endmodule

// File: tb/sim_pulse_burst_gen.sv
module sim_pulse_burst_gen;
    localparam int PW = 16;
    localparam int TW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig = 1'b0;
    logic [PW-1:0] c_n = '0;
    logic [TW-1:0] c_h = '0, c_l = '0, c_tl = '0;
    logic c_te = 1'b0;
    logic clr = 1'b0;
    logic pulse_out, busy, missed;

    int n_checks = 0, n_fail = 0, cyc = 0, bursts = 0;
    bit done = 1'b0;
    bit prev_busy = 1'b0;

    // Reference model state.
    bit q[$];
    bit m_trig_prev = 1'b0, m_miss = 1'b0;

    always #2 clk = ~clk;

    pulse_burst_gen #(.PCNT_W(PW), .TICK_W(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .trig_in(trig),
        .cfg_pulses(c_n), .cfg_high(c_h), .cfg_low(c_l),
        .cfg_tail_en(c_te), .cfg_tail_len(c_tl), .miss_clr(clr),
        .pulse_out(pulse_out), .busy(busy), .missed(missed)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s t=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
        end
    endtask

    // Behavioural model: on acceptance, queue the output levels of the whole burst.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            q.delete();
            m_trig_prev = 1'b0;
            m_miss = 1'b0;
        end else begin
            bit edge_seen, was_busy;
            edge_seen = trig && !m_trig_prev;
            was_busy = (q.size() != 0);
            if (was_busy) void'(q.pop_front());
            if (!was_busy && edge_seen) begin
                int n, h, l, t;
                n = (c_n == 0) ? 1 : int'(c_n);
                h = (c_h == 0) ? 1 : int'(c_h);
                l = (c_l == 0) ? 1 : int'(c_l);
                t = c_te ? ((c_tl < 2) ? 2 : int'(c_tl)) : l;
                for (int p = 0; p < n; p++) begin
                    for (int i = 0; i < h; i++) q.push_back(1'b1);
                    for (int i = 0; i < ((p == n - 1) ? t : l); i++) q.push_back(1'b0);
                end
            end
            if (was_busy && edge_seen) m_miss = 1'b1;
            else if (clr) m_miss = 1'b0;
            m_trig_prev = trig;
        end
    end

    // Compare every cycle away from the active edge; count bursts started.
    always @(negedge clk) begin
        if (rst_n) begin
            check("R3 pulse_out", int'(pulse_out), (q.size() != 0) ? int'(q[0]) : 0);
            check("R2 busy", int'(busy), int'(q.size() != 0));
            check("R8 missed", int'(missed), int'(m_miss));
            if (busy && !prev_busy) bursts++;
            prev_busy = busy;
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic fire(input int hold);
        trig = 1'b1;
        tick(hold);
        trig = 1'b0;
    endtask

    task automatic wait_idle();
        tick(1);
        while (busy) tick(1);
        tick(3);
    endtask

    task automatic set_cfg(input int n, input int h, input int l, input bit te, input int tl);
        c_n = PW'(n); c_h = TW'(h); c_l = TW'(l); c_te = te; c_tl = TW'(tl);
    endtask

    task automatic period_run(input bit te, input int expect_bursts, input string tag);
        set_cfg(10, 5, 5, te, 2);
        clr = 1'b1; tick(1); clr = 1'b0;
        bursts = 0;
        for (int k = 0; k < 10; k++) begin
            fire(1);
            tick(99);
        end
        wait_idle();
        check(tag, bursts, expect_bursts);
    endtask

    // Watchdog: a hung run is a failure and still reaches the summary.
    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R7: reset state is quiet.
        check("R7 reset pulse", int'(pulse_out), 0);
        check("R7 reset busy", int'(busy), 0);
        check("R8 reset missed", int'(missed), 0);

        // R1/R3/R7: basic burst, trigger level held for several cycles.
        set_cfg(3, 2, 3, 1'b0, 0);
        fire(4);
        wait_idle();

        // R10: zero counts behave as one.
        set_cfg(0, 0, 0, 1'b0, 0);
        fire(1);
        wait_idle();

        // R9/R2/R8: config change and trigger during a burst.
        set_cfg(4, 3, 2, 1'b0, 0);
        fire(1);
        tick(4);
        set_cfg(1, 1, 1, 1'b0, 0);
        fire(1);
        tick(3);
        clr = 1'b1; tick(1); clr = 1'b0;
        tick(1);
        // R8: miss and clear in the same cycle; the set wins.
        trig = 1'b1; clr = 1'b1; tick(1); trig = 1'b0; clr = 1'b0;
        wait_idle();
        check("R8 set beats clear", int'(missed), 1);
        // R9: the next burst uses the new settings.
        fire(1);
        wait_idle();
        clr = 1'b1; tick(1); clr = 1'b0;
        tick(1);
        check("R8 cleared", int'(missed), 0);

        // R5: shortened tail, length below floor and above.
        set_cfg(2, 3, 6, 1'b1, 0);
        fire(1);
        wait_idle();
        set_cfg(2, 3, 6, 1'b1, 4);
        fire(1);
        wait_idle();

        // R4/R5: trigger on the final low cycle of a burst (2*(2+2) = 8 cycles).
        set_cfg(2, 2, 2, 1'b0, 0);
        fire(1); tick(7); fire(1);
        wait_idle();
        check("R4 edge on last cycle missed", int'(missed), 1);
        clr = 1'b1; tick(1); clr = 1'b0;

        // R6: period equal to the burst length.
        period_run(1'b0, 5, "R6 default bursts");
        period_run(1'b1, 10, "R6 tail bursts");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule